// File: doc/BRIEF.md
# Hash Block Start and Status Controller

This unit is the register-facing control logic of a memory-mapped hash accelerator that works on 512-bit blocks. Software writes a block into sixteen 32-bit input words, picks an algorithm (SHA1 or SHA256) and a bandwidth setting, and starts the work. There are two start policies. In manual mode the engine waits for a START command. In automatic mode it starts once the whole block has been written. The unit counts down the busy time of a block. When the count ends it raises a data-ready flag and, if enabled, the interrupt line. The flag is cleared by the next start or by reading the digest.

The compression datapath is replaced by a stub. When a block ends, digest word i becomes B[i] XOR din[i] XOR din[i+8]. B is either the previous digest word or the initial word IV(i) = 0x9E3779B9 * (i+1), taken modulo 2^32. Software marks the first block of a message with a FIRST command, which selects the initial words.

Top module: `hash_start_ctrl`

Register map (byte addresses):

| Address | Register | Access |
|---|---|---|
| 0x00 | Control | write only |
| 0x04 | Mode | read and write |
| 0x08 | Interrupt enable | write 1 to set |
| 0x0C | Interrupt disable | write 1 to clear |
| 0x10 | Interrupt mask | read only |
| 0x14 | Status | read only |
| 0x40 + 4*k | Input word k, k = 0..15 | write only |
| 0x80 + 4*i | Digest word i, i = 0..7 | read only |

## Requirements
- R1: After reset, the status, mask and mode registers read 0, irq_o is 0, every digest word reads 0, and the next block that starts uses the initial words.
- R2: In manual mode (mode bits [1:0] = 0), a block starts only when 1 is written to control bit 0 (START). Writing all sixteen input words, or writing control with only bit 1 set, does not start a block.
- R3: In automatic mode (mode bits [1:0] nonzero), a block starts on a write to input word 15, provided every input word has been written since the last start. A write to word 15 alone after a block has started does not start a new one.
- R4: Busy time, counted in clock edges from the start edge to the edge that sets the ready flag, is 87 for SHA1 short, 328 for SHA1 long, 74 for SHA256 short and 267 for SHA256 long. Mode bit 4 = 1 selects SHA256; mode bit 8 = 1 selects the long period.
- R5: At the end of the busy time, status bit 0 (ready) is set and the digest words are updated. The ready flag stays set until something clears it.
- R6: A write with bit 0 = 1 to the enable register sets the mask bit. A write with bit 0 = 1 to the disable register clears it. irq_o equals ready AND mask.
- R7: Every block start clears the ready flag.
- R8: Reading any digest word clears the ready flag.
- R9: A block started with FIRST pending (set by writing control bit 1, or left pending after reset) computes its digest from the initial words. Any other block chains from the previous digest.
- R10: While busy (status bit 1 = 1), writes to input words and to the control register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| irq_o | output | 1 | Interrupt line |

## Verification
Some properties are checked on every cycle by the assertions:
- the ready flag is never set while a block is busy;
- ready only rises out of a busy period;
- a manual-mode start always follows a START write, and an automatic start always follows a write to word 15;
- the input words do not change while busy;
- a digest read leaves ready clear.

Other behaviour can only be shown by the bench scenarios:
- the exact busy length for each algorithm and period;
- the digest values across chained and FIRST blocks;
- masking and unmasking of the interrupt;
- the rule that a lone write to word 15 does not start a block.

// File: rtl/hash_start_ctrl.sv
`timescale 1ns/1ps
module hash_start_ctrl #(
  parameter int NWORDS       = 16,
  parameter int NDIG         = 8,
  parameter int SHA1_SHORT   = 85,
  parameter int SHA1_LONG    = 326,
  parameter int SHA256_SHORT = 72,
  parameter int SHA256_LONG  = 265,
  parameter int SYNC_CYC     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  localparam int CW   = $clog2(SHA1_LONG + SYNC_CYC + 1);
  localparam int HALF = NWORDS / 2;
  localparam int IW   = $clog2(NWORDS);
  localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_IEN = 8'h08,
                         A_IDIS = 8'h0C, A_MASK = 8'h10, A_STAT = 8'h14;

  function automatic logic [31:0] iv_word(int k);
    return 32'h9E3779B9 * 32'(k + 1);
  endfunction

  logic [NWORDS-1:0][31:0] din;
  logic [NDIG-1:0][31:0]   dig;
  logic [NWORDS-1:0]       filled;
  logic [1:0]              smode;
  logic                    algo, lng, busy, ready, mask, first_pend, chain_first;
  logic [CW-1:0]           cnt;

  logic              wr_din, ctrl_wr, man_go, auto_go, go, done, rd_dig, first_now;
  logic [IW-1:0]     widx;
  logic [NWORDS-1:0] filled_nx;
  logic [CW-1:0]     load;
  logic              unused_bits;

  assign widx      = bus_addr[IW+1:2];
  assign wr_din    = bus_wr && bus_addr[7:6] == 2'b01 && !busy;
  assign filled_nx = filled | (wr_din ? (NWORDS'(1) << widx) : '0);
  assign ctrl_wr   = bus_wr && bus_addr == A_CTRL && !busy;
  assign first_now = ctrl_wr && bus_wdata[1];
  assign man_go    = ctrl_wr && bus_wdata[0] && smode == 2'd0;
  assign auto_go   = wr_din && smode != 2'd0 && widx == IW'(NWORDS - 1) && &filled_nx;
  assign go        = man_go || auto_go;
  assign done      = busy && cnt == '0;
  assign rd_dig    = bus_rd && bus_addr[7:5] == 3'b100;
  assign irq_o     = ready && mask;
  assign load      = algo ? (lng ? CW'(SHA256_LONG + SYNC_CYC - 1) : CW'(SHA256_SHORT + SYNC_CYC - 1))
                          : (lng ? CW'(SHA1_LONG + SYNC_CYC - 1)   : CW'(SHA1_SHORT + SYNC_CYC - 1));
  assign unused_bits = ^{bus_wdata[31:9], bus_wdata[7:5], bus_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din <= '0; dig <= '0; filled <= '0; smode <= '0; algo <= 1'b0; lng <= 1'b0;
      busy <= 1'b0; ready <= 1'b0; mask <= 1'b0; first_pend <= 1'b1;
      chain_first <= 1'b0; cnt <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) begin
        smode <= bus_wdata[1:0];
        algo  <= bus_wdata[4];
        lng   <= bus_wdata[8];
      end
      if (bus_wr && bus_addr == A_IDIS && bus_wdata[0]) mask <= 1'b0;
      else if (bus_wr && bus_addr == A_IEN && bus_wdata[0]) mask <= 1'b1;
      if (wr_din) din[widx] <= bus_wdata;
      filled <= go ? '0 : filled_nx;
      if (go) begin
        first_pend  <= 1'b0;
        chain_first <= first_pend || first_now;
        busy        <= 1'b1;
        cnt         <= load;
      end else begin
        if (first_now) first_pend <= 1'b1;
        if (done) busy <= 1'b0;
        else if (busy) cnt <= cnt - 1'b1;
      end
      if (done) ready <= 1'b1;
      else if (go || rd_dig) ready <= 1'b0;
      if (done)
        for (int i = 0; i < NDIG; i++)
          dig[i] <= (chain_first ? iv_word(i) : dig[i]) ^ din[i] ^ din[i+HALF];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_MODE)      bus_rdata = {23'd0, lng, 3'd0, algo, 2'd0, smode};
      else if (bus_addr == A_MASK) bus_rdata = {31'd0, mask};
      else if (bus_addr == A_STAT) bus_rdata = {30'd0, busy, ready};
      else if (rd_dig)             bus_rdata = dig[bus_addr[4:2]];
    end
  end

  AST_MANUAL_START_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && smode == 2'd0 |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[0])); // R2
  AST_AUTO_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && smode != 2'd0 |-> $past(bus_wr && bus_addr == 8'h7C)); // R3
  AST_READY_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(busy)); // R5
  AST_NO_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready); // R7
  AST_DIGEST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr[7:5] == 3'b100 && !busy |=> !ready); // R8
  AST_BUSY_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(din)); // R10
endmodule

// File: tb/hash_start_ctrl_tb.sv
`timescale 1ns/1ps
module hash_start_ctrl_tb;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  hash_start_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #10 clk = ~clk;

  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_dig [8];
  logic [31:0] blk [16];
  bit          mfirst = 1'b1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] iv(int k);
    return 32'h9E3779B9 * 32'(k + 1);
  endfunction

  function automatic int total(bit algo, bit lng);
    return algo ? (lng ? 267 : 74) : (lng ? 328 : 87);
  endfunction

  function automatic logic [31:0] mode_word(int sm, bit algo, bit lng);
    return {23'd0, lng, 3'd0, algo, 2'd0, 2'(sm)};
  endfunction

  task automatic model_block(bit first);
    for (int i = 0; i < 8; i++)
      exp_dig[i] = ((first || mfirst) ? iv(i) : exp_dig[i]) ^ blk[i] ^ blk[i+8];
    mfirst = 1'b0;
  endtask

  task automatic wait_done(int tot, int used);
    repeat (tot - 1 - used) @(negedge clk);
    chk("R4 busy length, irq still low", 32'(irq_o), 0);
    @(negedge clk);
    chk("R4/R5 ready raised at end of busy time", 32'(irq_o), 1);
  endtask

  task automatic read_digest(string req);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(8'(128 + 4 * i), v);
      chk(req, v, exp_dig[i]);
    end
    rd(8'h14, v);
    chk("R8 ready cleared by digest read", v, 0);
  endtask

  task automatic run_block(int sm, bit algo, bit lng, bit first, bit rdd);
    logic [31:0] v;
    wr(8'h04, mode_word(sm, algo, lng));
    if (first) wr(8'h00, 32'd2);
    for (int i = 0; i < 16; i++) blk[i] = $urandom;
    for (int i = 0; i < 16; i++) wr(8'(64 + 4 * i), blk[i]);
    if (sm == 0) begin
      rd(8'h14, v);
      chk("R2 no start before START command", 32'(v[1]), 0);
      wr(8'h00, 32'd1);
    end
    chk("R7 ready cleared by start", 32'(irq_o), 0);
    wait_done(total(algo, lng), 0);
    model_block(first);
    if (rdd) read_digest("R5/R9 digest word");
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h14, v); chk("R1 status after reset", v, 0);
    rd(8'h10, v); chk("R1 mask after reset", v, 0);
    rd(8'h04, v); chk("R1 mode after reset", v, 0);
    rd(8'h80, v); chk("R1 digest after reset", v, 0);
    chk("R1 irq after reset", 32'(irq_o), 0);

    wr(8'h08, 32'd1);
    rd(8'h10, v); chk("R6 mask set by enable write", v, 1);

    wr(8'h00, 32'd2);
    rd(8'h14, v); chk("R2 FIRST alone does not start", 32'(v[1]), 0);
    run_block(0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_block(0, 1'b1, 1'b1, 1'b0, 1'b1);
    run_block(1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 ready holds after completion", 32'(irq_o), 1);

    wr(8'h0C, 32'd1);
    chk("R6 irq masked after disable write", 32'(irq_o), 0);
    rd(8'h10, v); chk("R6 mask cleared by disable write", v, 0);
    wr(8'h08, 32'd1);
    chk("R6 irq returns after enable write", 32'(irq_o), 1);

    wr(8'h7C, 32'h12345678);
    blk[15] = 32'h12345678;
    rd(8'h14, v);
    chk("R3 lone write to word 15 does not start", v, 32'd1);

    wr(8'h04, mode_word(0, 1'b0, 1'b1));
    for (int i = 0; i < 16; i++) begin
      blk[i] = $urandom;
      wr(8'(64 + 4 * i), blk[i]);
    end
    wr(8'h00, 32'd1);
    wr(8'h40, 32'hDEADBEEF);
    wr(8'h00, 32'd3);
    wait_done(total(1'b0, 1'b1), 4);
    model_block(1'b0);
    read_digest("R10 busy writes ignored, digest word");

    run_block(2, 1'b0, 1'b0, 1'b1, 1'b1);

    for (int n = 0; n < 8; n++)
      run_block(int'($urandom_range(0, 2)), 1'($urandom), 1'($urandom),
                1'($urandom), ($urandom_range(0, 3) != 0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule